// File: doc/BRIEF.md
# GPIO external interrupt controller

This block gathers up to 224 pin-level interrupt sources, sorts them into seven 32-bit groups and raises one interrupt line per group toward a downstream vectored interrupt controller. Each source is first passed through a two-flop synchroniser. It is then qualified by its own polarity bit and its own edge-or-level mode bit. It is latched or followed in a status bit, and it is gated by an enable bit. The group line is the OR of the enabled status bits of that group.

Source numbers are not placed in the groups in linear order. Higher source numbers land in lower groups, and within a group word the four bytes are reversed while the bit order inside each byte is kept. Several positions cannot be used and always read zero: two whole groups, four positions of a third group, and all but two positions of group 0. Software programs the block through a small word-wide register bus. Reads return data in the same cycle and writes take effect at the next clock edge.

Top module: `gpio_eint_ctrl`

## Requirements
- R1: Registers are word-aligned byte addresses: polarity of group g at 0x80+4g, status at 0xA0+4g, enable at 0xC0+4g, mode at 0xE0+4g. Any other address, including one with a nonzero low address bit pair or a group index of 7, reads zero. After reset every register reads zero and every interrupt line is low.
- R2: Source n belongs to group 6 - floor(n/32).
- R3: Within its group, source n sits at bit ((0x18 - (n & 0x18)) | (n & 7)), so byte k of the group's sources appears in byte 3-k of the register word.
- R4: A polarity bit of 1 makes its source active-high and 0 makes it active-low. A mode bit of 0 selects edge mode and 1 selects level mode.
- R5: In edge mode a status bit sets on the active edge of the synchronised input, meaning a rising edge for active-high and a falling edge for active-low. It stays set until software writes 1 to it. Writing 0 leaves it unchanged, and the inactive edge does not set it.
- R6: In level mode a status bit reads as the synchronised input qualified by polarity, and writes to it have no effect.
- R7: Group g drives eint_o[6-g], which is high exactly when some bit of that group is both set in status and set in enable.
- R8: Groups 1 and 2 are unusable: their enable and status read zero whatever is written or driven, and eint_o[5] and eint_o[4] stay low.
- R9: In group 3, the sources 124 to 127 (bits 4 to 7) are unusable: those enable and status bits read zero, so group 3 enable written with all ones reads 0xFFFFFF0F.
- R10: In group 0 only bits 0 (source 0xD8) and 2 (source 0xDA) are usable; group 0 enable written with all ones reads 0x00000005 and other group 0 sources never set status.
- R11: A source change driven just after an edge E0 shows at the group line after the second following edge in level mode, and after the third following edge in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 224 | Raw interrupt sources, bit n is source n |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| eint_o | output | 7 | Group interrupt lines, eint_o[k] driven by group 6-k |

## Verification
The hardest situation to reach is an unusable position that sits right beside a live one in the same word. Such a position must stay silent in both status and line even while its pin toggles with the group fully enabled and set to active-high. The stimulus reaches it by writing all ones to the polarity and enable of groups 0 to 3 and then toggling exactly the pin whose remapped position is masked. Status and lines are read back, and the same word is then shown to latch a neighbouring live source. The remap is covered by a table of hand-computed source, line and bit triples that includes sources at byte borders of each group.

// File: rtl/eint_pkg.sv
package eint_pkg;

  typedef enum logic [1:0] {
    KIND_POL  = 2'd0,
    KIND_STAT = 2'd1,
    KIND_EN   = 2'd2,
    KIND_MODE = 2'd3
  } reg_kind_e;

  // group that holds source n: higher sources land in lower groups
  function automatic int unsigned src_group(int unsigned n, int unsigned ngrp,
                                            int unsigned w);
    return ngrp - 1 - n / w;
  endfunction

  // bit position of source n inside its group word: bytes reversed
  function automatic int unsigned src_bit(int unsigned n, int unsigned w);
    int unsigned byte_idx;
    byte_idx = (n % w) / 8;
    return (w / 8 - 1 - byte_idx) * 8 + n % 8;
  endfunction

  // positions that can hold an enable or status bit
  function automatic logic [63:0] usable_bits(int unsigned g, int unsigned w);
    logic [63:0] m;
    m = '0;
    for (int unsigned i = 0; i < w; i++) m[i] = 1'b1;
    if (g == 1 || g == 2) begin
      m = '0;
    end else if (g == 0) begin
      m = 64'h5;
    end else if (g == 3) begin
      for (int unsigned k = w - 4; k < w; k++) m[src_bit(k, w)] = 1'b0;
    end
    return m;
  endfunction

endpackage

// File: rtl/eint_rst_sync.sv
module eint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/eint_sync2.sv
module eint_sync2 #(
  parameter int W = 224
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/eint_group.sv
module eint_group #(
  parameter int           W      = 32,
  parameter logic [W-1:0] USABLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic         wr_pol_i,
  input  logic         wr_stat_i,
  input  logic         wr_en_i,
  input  logic         wr_mode_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mode_o,
  output logic         irq_o
);
  logic [W-1:0] pol_q, mode_q, en_q, st_q, prev_q;
  logic [W-1:0] en_d, st_d;
  logic [W-1:0] qual_now, qual_prev, hit, clr;

  // next-state logic
  always_comb begin
    qual_now  = ~(pin_i  ^ pol_q);
    qual_prev = ~(prev_q ^ pol_q);
    hit       = qual_now & ~qual_prev & ~mode_q & USABLE;
    clr       = wr_stat_i ? wdata_i : '0;
    st_d      = ((st_q & ~clr) | hit) & ~mode_q & USABLE;
    en_d      = wdata_i & USABLE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      mode_q <= '0;
      en_q   <= '0;
      st_q   <= '0;
      prev_q <= '0;
    end else begin
      if (wr_pol_i)  pol_q  <= wdata_i;
      if (wr_mode_i) mode_q <= wdata_i;
      if (wr_en_i)   en_q   <= en_d;
      st_q   <= st_d;
      prev_q <= pin_i;
    end
  end

  assign pol_o  = pol_q;
  assign mode_o = mode_q;
  assign en_o   = en_q;
  assign stat_o = (mode_q ? qual_now : st_q) & USABLE;
  assign irq_o  = |(stat_o & en_q);
endmodule

// File: rtl/gpio_eint_ctrl.sv
module gpio_eint_ctrl #(
  parameter int NUM_GRP = 7,
  parameter int GRP_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GRP*GRP_W-1:0]   src_i,
  input  logic                       bus_sel_i,
  input  logic                       bus_we_i,
  input  logic [7:0]                 bus_addr_i,
  input  logic [GRP_W-1:0]           bus_wdata_i,
  output logic [GRP_W-1:0]           bus_rdata_o,
  output logic [NUM_GRP-1:0]         eint_o
);
  import eint_pkg::*;

  localparam int NSRC = NUM_GRP * GRP_W;

  logic rst_sync_n;
  logic [NSRC-1:0] src_sync;
  logic [GRP_W-1:0] grp_pin [NUM_GRP];
  logic [GRP_W-1:0] pol_v [NUM_GRP];
  logic [GRP_W-1:0] st_v  [NUM_GRP];
  logic [GRP_W-1:0] en_v  [NUM_GRP];
  logic [GRP_W-1:0] md_v  [NUM_GRP];
  logic [NUM_GRP-1:0] irq_v;

  reg_kind_e  kind;
  logic [2:0] gsel;
  logic       reg_hit;

  eint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eint_sync2 #(.W(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  // source number to group/bit remap
  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) grp_pin[g] = '0;
    for (int unsigned n = 0; n < NSRC; n++)
      grp_pin[src_group(n, NUM_GRP, GRP_W)][src_bit(n, GRP_W)] = src_sync[n];
  end

  // address decode
  always_comb begin
    kind    = reg_kind_e'(bus_addr_i[6:5]);
    gsel    = bus_addr_i[4:2];
    reg_hit = bus_sel_i && bus_addr_i[7] && (bus_addr_i[1:0] == 2'b00)
              && (int'(gsel) < NUM_GRP);
  end

  for (genvar gi = 0; gi < NUM_GRP; gi++) begin : g_grp
    localparam logic [63:0] MASK64 = usable_bits(gi, GRP_W);
    logic sel_g;
    assign sel_g = reg_hit && bus_we_i && (int'(gsel) == gi);

    eint_group #(.W(GRP_W), .USABLE(MASK64[GRP_W-1:0])) u_grp (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .pin_i     (grp_pin[gi]),
      .wr_pol_i  (sel_g && kind == KIND_POL),
      .wr_stat_i (sel_g && kind == KIND_STAT),
      .wr_en_i   (sel_g && kind == KIND_EN),
      .wr_mode_i (sel_g && kind == KIND_MODE),
      .wdata_i   (bus_wdata_i),
      .pol_o     (pol_v[gi]),
      .stat_o    (st_v[gi]),
      .en_o      (en_v[gi]),
      .mode_o    (md_v[gi]),
      .irq_o     (irq_v[gi])
    );
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (reg_hit && !bus_we_i) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (int'(gsel) == g) begin
          unique case (kind)
            KIND_POL:  bus_rdata_o = pol_v[g];
            KIND_STAT: bus_rdata_o = st_v[g];
            KIND_EN:   bus_rdata_o = en_v[g];
            KIND_MODE: bus_rdata_o = md_v[g];
          endcase
        end
      end
    end
  end

  // group g drives line NUM_GRP-1-g
  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) eint_o[NUM_GRP-1-g] = irq_v[g];
  end
endmodule

// File: rtl/eint_chk.sv
module eint_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        we,
  input logic [7:0]  addr,
  input logic [31:0] rdata,
  input logic [6:0]  eint,
  input logic [31:0] st0,
  input logic [31:0] mode0
);
  // R1
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && (!addr[7] || addr[1:0] != 2'b00 || addr[4:2] == 3'd7))
      |-> (rdata == 32'h0));

  // R8
  dead_grp_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && addr[7] && addr[6:5] inside {2'd1, 2'd2}
     && addr[4:2] inside {3'd1, 3'd2}) |-> (rdata == 32'h0));

  // R8
  dead_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eint[5] && !eint[4]);

  // R9
  grp3_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && addr[7] && addr[6:5] inside {2'd1, 2'd2} && addr[4:2] == 3'd3
     && addr[1:0] == 2'b00) |-> (rdata[7:4] == 4'h0));

  // R10
  grp0_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && addr[7] && addr[6:5] inside {2'd1, 2'd2} && addr[4:2] == 3'd0
     && addr[1:0] == 2'b00) |-> ((rdata & ~32'h5) == 32'h0));

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && we && addr == 8'hA0) && mode0 == 32'h0)
      |=> (($past(st0) & ~st0) == 32'h0));
endmodule

bind gpio_eint_ctrl eint_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .sel   (bus_sel_i),
  .we    (bus_we_i),
  .addr  (bus_addr_i),
  .rdata (bus_rdata_o),
  .eint  (eint_o),
  .st0   (g_grp[0].u_grp.st_q),
  .mode0 (g_grp[0].u_grp.mode_q)
);

// File: tb/gpio_eint_ctrl_bench.sv
module gpio_eint_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [223:0] src;
  logic         bus_sel, bus_we;
  logic [7:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [6:0]   eint;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_eint_ctrl u_gpio_eint_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_sel_i   (bus_sel),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .eint_o      (eint)
  );

  // {source[7:0], line[3:0], bit[7:0]}, worked out by hand from R2/R3
  localparam logic [19:0] VEC [0:9] = '{
    20'h00_0_18, 20'h09_0_11, 20'h1F_0_07, 20'h28_1_10, 20'h3F_1_07,
    20'h46_2_1E, 20'h64_3_1C, 20'h7B_3_03, 20'hD8_6_00, 20'hDA_6_02
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_sel = 1'b1; bus_we = 1'b0;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  ga;
    rst_n = 1'b0; src = '0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state and unmapped addresses
    for (int g = 0; g < 7; g++) begin
      for (int k = 0; k < 4; k++) begin
        rd(8'h80 + 8'(k*32) + 8'(g*4), d);
        chk("R1 reset reg", d, 32'h0);
      end
    end
    chk("R1 reset lines", {25'h0, eint}, 32'h0);
    wr(8'hC0 + 8'd24, 32'hFFFF_FFFF);
    rd(8'h10, d);   chk("R1 low addr", d, 32'h0);
    rd(8'hDC, d);   chk("R1 group index 7", d, 32'h0);
    rd(8'h81, d);   chk("R1 misaligned", d, 32'h0);
    rd(8'hD8, d);   chk("R1 group 6 enable", d, 32'hFFFF_FFFF);
    wr(8'hC0 + 8'd24, 32'h0);

    // R2 R3 R7 remap table
    for (int i = 0; i < 10; i++) begin
      int s, ln, bp, grp;
      logic [31:0] en_exp;
      s = int'(VEC[i][19:12]); ln = int'(VEC[i][11:8]); bp = int'(VEC[i][7:0]);
      grp = 6 - ln;
      ga  = 8'(grp * 4);
      en_exp = (grp == 0) ? 32'h5 : (grp == 3) ? 32'hFFFF_FF0F : 32'hFFFF_FFFF;
      wr(8'h80 + ga, 32'hFFFF_FFFF);
      wr(8'hE0 + ga, 32'h0);
      wr(8'hC0 + ga, 32'hFFFF_FFFF);
      rd(8'hC0 + ga, d); chk("R9 R10 enable readback", d, en_exp);
      src[s] = 1'b1;
      idle(4);
      rd(8'hA0 + ga, d); chk("R2 R3 status bit", d, 32'h1 << bp);
      chk("R7 line", {25'h0, eint}, 32'h1 << ln);
      wr(8'hA0 + ga, 32'h1 << bp);
      rd(8'hA0 + ga, d); chk("R5 w1c clears", d, 32'h0);
      chk("R7 line low after clear", {25'h0, eint}, 32'h0);
      src[s] = 1'b0;
      idle(3);
      wr(8'h80 + ga, 32'h0);
      wr(8'hC0 + ga, 32'h0);
    end

    // R4 R5 active-low edge on source 0 (group 6 bit 24)
    wr(8'h98, 32'h0); wr(8'hF8, 32'h0); wr(8'hD8, 32'h0100_0000);
    src[0] = 1'b1; idle(4);
    rd(8'hB8, d); chk("R4 inactive edge ignored", d, 32'h0);
    src[0] = 1'b0; idle(4);
    rd(8'hB8, d); chk("R4 falling edge latches", d, 32'h0100_0000);
    chk("R7 line 0 set", {25'h0, eint}, 32'h1);
    wr(8'hB8, 32'h0);
    rd(8'hB8, d); chk("R5 write 0 keeps", d, 32'h0100_0000);
    wr(8'hB8, 32'h0100_0000);
    rd(8'hB8, d); chk("R5 write 1 clears", d, 32'h0);

    // R11 edge latency
    wr(8'h98, 32'h0100_0000);
    src[0] = 1'b1;
    @(posedge clk); #1 chk("R11 edge after 1", {25'h0, eint}, 32'h0);
    @(posedge clk); #1 chk("R11 edge after 2", {25'h0, eint}, 32'h0);
    @(posedge clk); #1 chk("R11 edge after 3", {25'h0, eint}, 32'h1);
    @(negedge clk); src[0] = 1'b0;
    idle(3);
    wr(8'hB8, 32'hFFFF_FFFF);
    // R11 level latency
    wr(8'hF8, 32'h0100_0000);
    rd(8'hB8, d); chk("R6 level idle", d & 32'h0100_0000, 32'h0);
    src[0] = 1'b1;
    @(posedge clk); #1 chk("R11 level after 1", {25'h0, eint}, 32'h0);
    @(posedge clk); #1 chk("R11 level after 2", {25'h0, eint}, 32'h1);
    // R6 writes ignored in level mode
    wr(8'hB8, 32'hFFFF_FFFF);
    rd(8'hB8, d); chk("R6 level ignores w1c", d & 32'h0100_0000, 32'h0100_0000);
    src[0] = 1'b0; idle(3);
    rd(8'hB8, d); chk("R6 level follows input", d & 32'h0100_0000, 32'h0);
    chk("R6 line low", {25'h0, eint}, 32'h0);
    // R4 active-low level: all inputs low read as active
    wr(8'h98, 32'h0); wr(8'hF8, 32'hFFFF_FFFF);
    rd(8'hB8, d); chk("R4 active-low level", d, 32'hFFFF_FFFF);
    wr(8'hD8, 32'h0); wr(8'hF8, 32'h0);

    // R8 dead groups 1 and 2
    wr(8'h84, 32'hFFFF_FFFF); wr(8'hE4, 32'hFFFF_FFFF); wr(8'hC4, 32'hFFFF_FFFF);
    wr(8'h88, 32'hFFFF_FFFF); wr(8'hC8, 32'hFFFF_FFFF);
    rd(8'hC4, d); chk("R8 group 1 enable", d, 32'h0);
    rd(8'hC8, d); chk("R8 group 2 enable", d, 32'h0);
    src[170] = 1'b1; src[140] = 1'b1; idle(4);
    rd(8'hA4, d); chk("R8 group 1 status", d, 32'h0);
    rd(8'hA8, d); chk("R8 group 2 status", d, 32'h0);
    chk("R8 lines", {25'h0, eint}, 32'h0);
    src[170] = 1'b0; src[140] = 1'b0;

    // R9 group 3 source 124 masked (bit 4)
    wr(8'h8C, 32'hFFFF_FFFF); wr(8'hEC, 32'h0); wr(8'hCC, 32'hFFFF_FFFF);
    src[124] = 1'b1; idle(4);
    rd(8'hAC, d); chk("R9 masked source", d, 32'h0);
    chk("R9 line 3 low", {25'h0, eint}, 32'h0);
    src[123] = 1'b1; idle(4);
    rd(8'hAC, d); chk("R9 live neighbour", d, 32'h8);
    src[124] = 1'b0; src[123] = 1'b0;

    // R10 group 0 source 0xD9 (bit 1) masked
    wr(8'h80, 32'hFFFF_FFFF); wr(8'hE0, 32'h0); wr(8'hC0, 32'hFFFF_FFFF);
    src[217] = 1'b1; idle(4);
    rd(8'hA0, d); chk("R10 masked source", d, 32'h0);
    chk("R10 line 6 low", {25'h0, eint[6]}, 32'h0);

    idle(2);
    finish_run();
  end
endmodule